// File: doc/BRIEF.md
# Combinable Skip Condition Unit

This block executes one class of 12-bit operate words: those that test machine state and optionally skip the next instruction. Three condition tests can be picked in one word: accumulator negative, accumulator zero, and link set. A sense bit chooses how the picked tests combine. With sense clear, the block skips when any picked test is true. With sense set, the block skips only when every picked test is false, which is the inverse of the any-true result. The same word can also clear the accumulator, OR a 12-bit switch value into it, and request a halt. The clear, OR and halt actions do not depend on the sense bit.

The caller presents a word with `valid_i` for one cycle, together with the current accumulator, link and switch value. On the next clock edge the block registers the new accumulator and raises `done_o` for one cycle, along with the skip and halt pulses. The caller handles the program counter increment and any halt sequencing. The link is read but never written.

Top module: `opr2_skip_unit`

## Requirements
Bit positions in a word are numbered from the most significant bit: position 0 is `instr_i[11]` and position 11 is `instr_i[0]`.

- R1: A word belongs to this unit when positions 0–3 are all 1 and position 11 is 0. Such a word with `valid_i` high raises `done_o` for exactly the next cycle. Any other word, or `valid_i` low, gives no `done_o`, no skip and no halt, and leaves `acc_o` unchanged.
- R2: With position 8 clear, `skip_o` is high when at least one picked test is true. Position 5 picks "accumulator negative" (accumulator MSB set), position 6 picks "accumulator all zero", and position 7 picks "link is 1". For example, octal 7540 skips when the accumulator is ≤ 0.
- R3: With position 8 set, `skip_o` is the inverse of the any-true result from R2. For example, octal 7550 skips when the accumulator is > 0, and octal 7430 skips when the link is 0.
- R4: When none of positions 5–7 is set, the word skips unconditionally if position 8 is set (octal 7410) and never skips if position 8 is clear (octal 7400).
- R5: The condition tests use the accumulator value presented with the word, before any clear.
- R6: Position 4 set makes `acc_o` zero before the switch OR is applied. With positions 4 and 9 both clear, `acc_o` equals the input accumulator.
- R7: Position 9 ORs `sw_i` into the accumulator after the clear. Clear plus OR therefore loads `sw_i` exactly.
- R8: Position 10 raises `halt_o` with `done_o`, whether position 8 is set or clear.
- R9: `skip_o` and `halt_o` are single-cycle pulses and are only ever high together with `done_o`.
- R10: While `rst_n` is low, `acc_o`, `skip_o`, `halt_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Word present this cycle |
| instr_i | input | 12 | Operate word |
| link_i | input | 1 | Current link bit |
| acc_i | input | 12 | Current accumulator |
| sw_i | input | 12 | Switch register value |
| acc_o | output | 12 | Updated accumulator (held between words) |
| skip_o | output | 1 | Skip pulse |
| halt_o | output | 1 | Halt request pulse |
| done_o | output | 1 | Word executed pulse |

## Verification
Each single test is driven with accumulator values on both sides of its condition: MSB set versus a small positive value, zero versus non-zero, and link 1 versus 0. This separates a correct test from a stuck or swapped one. The compound sign/zero tests are driven with negative, zero and positive accumulators in both sense settings, which separates OR combining from AND combining and catches a missing inversion. Clear combined with a test on a non-zero accumulator shows whether the tests read the value before or after the clear. Clear combined with the switch OR on an all-ones accumulator shows the order of the two actions. Words from other groups, and idle cycles, show that the accumulator holds and that no pulse appears.

// File: rtl/opr2_pkg.sv
package opr2_pkg;
  localparam int WORD_W = 12;

  // Decoded fields of one operate word (MSB-first position in comments)
  typedef struct packed {
    logic member;  // positions 0-3 all ones, position 11 zero
    logic clr;     // position 4
    logic t_neg;   // position 5
    logic t_zero;  // position 6
    logic t_link;  // position 7
    logic sense;   // position 8
    logic osr;     // position 9
    logic hlt;     // position 10
  } opr2_fields_t;

  // Map MSB-first position to a vector index
  function automatic int pos2idx(input int pos);
    return WORD_W - 1 - pos;
  endfunction
endpackage

// File: rtl/opr2_decode.sv
module opr2_decode
  import opr2_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output opr2_fields_t      fields
);
  localparam int IDX_CLR   = pos2idx(4);
  localparam int IDX_NEG   = pos2idx(5);
  localparam int IDX_ZERO  = pos2idx(6);
  localparam int IDX_LINK  = pos2idx(7);
  localparam int IDX_SENSE = pos2idx(8);
  localparam int IDX_OSR   = pos2idx(9);
  localparam int IDX_HLT   = pos2idx(10);
  localparam int IDX_TAIL  = pos2idx(11);
  localparam int IDX_TOP   = pos2idx(0);
  localparam int IDX_TOPLO = pos2idx(3);

  always_comb begin
    fields.member = (&instr[IDX_TOP:IDX_TOPLO]) & ~instr[IDX_TAIL];
    fields.clr    = instr[IDX_CLR];
    fields.t_neg  = instr[IDX_NEG];
    fields.t_zero = instr[IDX_ZERO];
    fields.t_link = instr[IDX_LINK];
    fields.sense  = instr[IDX_SENSE];
    fields.osr    = instr[IDX_OSR];
    fields.hlt    = instr[IDX_HLT];
  end
endmodule

// File: rtl/opr2_skip_eval.sv
module opr2_skip_eval
  import opr2_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr2_fields_t      fields,
  input  logic [DATA_W-1:0] acc,
  input  logic              link,
  output logic              skip
);
  localparam int NCOND = 3;

  logic [NCOND-1:0] pick;
  logic [NCOND-1:0] hold;
  logic             any_true;

  // Conditions are taken from the incoming accumulator, ahead of any clear
  always_comb begin
    pick = {fields.t_neg, fields.t_zero, fields.t_link};
    hold = {acc[DATA_W-1], ~|acc, link};
  end

  always_comb begin
    any_true = |(pick & hold);
    skip     = any_true ^ fields.sense;
  end
endmodule

// File: rtl/opr2_acc_path.sv
module opr2_acc_path
  import opr2_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr2_fields_t      fields,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] sw,
  output logic [DATA_W-1:0] acc_nx
);
  logic [DATA_W-1:0] after_clr;

  // Clear first, switch OR second
  always_comb begin
    after_clr = fields.clr ? '0 : acc;
    acc_nx    = fields.osr ? (after_clr | sw) : after_clr;
  end
endmodule

// File: rtl/opr2_skip_unit.sv
module opr2_skip_unit
  import opr2_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              done_o
);
  opr2_fields_t      fields;
  logic              skip_c;
  logic [DATA_W-1:0] acc_c;
  logic              fire;

  logic [DATA_W-1:0] acc_q, acc_d;
  logic              skip_q, skip_d;
  logic              halt_q, halt_d;
  logic              done_q, done_d;
  logic              acc_en;

  opr2_decode u_dec (
    .instr  (instr_i),
    .fields (fields)
  );

  opr2_skip_eval #(.DATA_W(DATA_W)) u_eval (
    .fields (fields),
    .acc    (acc_i),
    .link   (link_i),
    .skip   (skip_c)
  );

  opr2_acc_path #(.DATA_W(DATA_W)) u_acc (
    .fields (fields),
    .acc    (acc_i),
    .sw     (sw_i),
    .acc_nx (acc_c)
  );

  // Next-state logic
  always_comb begin
    fire   = valid_i & fields.member;
    acc_en = fire;
    acc_d  = acc_c;
    skip_d = fire & skip_c;
    halt_d = fire & fields.hlt;
    done_d = fire;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      skip_q <= skip_d;
      halt_q <= halt_d;
      done_q <= done_d;
    end
  end

  assign acc_o  = acc_q;
  assign skip_o = skip_q;
  assign halt_o = halt_q;
  assign done_o = done_q;
endmodule

// File: rtl/opr2_skip_unit_chk.sv
module opr2_skip_unit_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [11:0]       instr_i,
  input logic [DATA_W-1:0] sw_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              skip_o,
  input logic              halt_o,
  input logic              done_o
);
  logic in_grp;
  assign in_grp = (instr_i[11:8] == 4'hF) && !instr_i[0];

  // R1: done only after a member word with valid
  a_r1_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(valid_i && in_grp));

  // R1: idle or foreign words leave the accumulator alone
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && in_grp) |=> ($stable(acc_o) && !done_o));

  // R4: sense set with no test picked always skips
  a_r4_uncond: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && in_grp && instr_i[3] && instr_i[6:4] == 3'b000) |=> skip_o);

  // R4: sense clear with no test picked never skips
  a_r4_never: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && in_grp && !instr_i[3] && instr_i[6:4] == 3'b000) |=> !skip_o);

  // R7: clear plus switch OR loads the switches
  a_r7_load_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && in_grp && instr_i[7] && instr_i[2]) |=> (acc_o == $past(sw_i)));

  // R8: halt follows the halt position regardless of sense
  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && in_grp && instr_i[1]) |=> halt_o);

  // R9: pulses only with done
  a_r9_skip_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> done_o);
  a_r9_halt_done: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> done_o);
endmodule

bind opr2_skip_unit opr2_skip_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_i (valid_i),
  .instr_i (instr_i),
  .sw_i    (sw_i),
  .acc_o   (acc_o),
  .skip_o  (skip_o),
  .halt_o  (halt_o),
  .done_o  (done_o)
);

// File: tb/opr2_skip_unit_tb.sv
module opr2_skip_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [11:0] instr_i;
  logic        link_i;
  logic [11:0] acc_i;
  logic [11:0] sw_i;
  logic [11:0] acc_o;
  logic        skip_o, halt_o, done_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  opr2_skip_unit u_dut (
    .clk (clk), .rst_n (rst_n), .valid_i (valid_i), .instr_i (instr_i),
    .link_i (link_i), .acc_i (acc_i), .sw_i (sw_i), .acc_o (acc_o),
    .skip_o (skip_o), .halt_o (halt_o), .done_o (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {tag, instr, acc, link, sw, exp_acc, exp_skip, exp_halt}
  localparam int NV = 27;
  localparam logic [54:0] VEC [NV] = '{
    {4'd2,  12'o7500, 12'o4000, 1'b0, 12'o0000, 12'o4000, 1'b1, 1'b0}, // R2 neg
    {4'd2,  12'o7500, 12'o0001, 1'b0, 12'o0000, 12'o0001, 1'b0, 1'b0}, // R2 pos
    {4'd2,  12'o7440, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0}, // R2 zero
    {4'd2,  12'o7440, 12'o0010, 1'b0, 12'o0000, 12'o0010, 1'b0, 1'b0}, // R2 nonzero
    {4'd2,  12'o7420, 12'o0005, 1'b1, 12'o0000, 12'o0005, 1'b1, 1'b0}, // R2 link 1
    {4'd2,  12'o7420, 12'o0005, 1'b0, 12'o0000, 12'o0005, 1'b0, 1'b0}, // R2 link 0
    {4'd2,  12'o7540, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0}, // R2 <=0 zero
    {4'd2,  12'o7540, 12'o7777, 1'b0, 12'o0000, 12'o7777, 1'b1, 1'b0}, // R2 <=0 neg
    {4'd2,  12'o7540, 12'o0001, 1'b1, 12'o0000, 12'o0001, 1'b0, 1'b0}, // R2 <=0 pos
    {4'd2,  12'o7560, 12'o0001, 1'b1, 12'o0000, 12'o0001, 1'b1, 1'b0}, // R2 any of three
    {4'd3,  12'o7550, 12'o0001, 1'b0, 12'o0000, 12'o0001, 1'b1, 1'b0}, // R3 >0
    {4'd3,  12'o7550, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R3 zero
    {4'd3,  12'o7550, 12'o4000, 1'b0, 12'o0000, 12'o4000, 1'b0, 1'b0}, // R3 neg
    {4'd3,  12'o7430, 12'o0003, 1'b0, 12'o0000, 12'o0003, 1'b1, 1'b0}, // R3 link 0
    {4'd3,  12'o7430, 12'o0003, 1'b1, 12'o0000, 12'o0003, 1'b0, 1'b0}, // R3 link 1
    {4'd3,  12'o7510, 12'o0002, 1'b0, 12'o0000, 12'o0002, 1'b1, 1'b0}, // R3 >=0
    {4'd4,  12'o7410, 12'o0123, 1'b0, 12'o0000, 12'o0123, 1'b1, 1'b0}, // R4 always
    {4'd4,  12'o7400, 12'o0000, 1'b1, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R4 never
    {4'd5,  12'o7640, 12'o0005, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b0}, // R5 test before clear
    {4'd5,  12'o7650, 12'o0005, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0}, // R5 inverted
    {4'd6,  12'o7600, 12'o7777, 1'b0, 12'o1234, 12'o0000, 1'b0, 1'b0}, // R6 clear
    {4'd6,  12'o7400, 12'o4321, 1'b0, 12'o7777, 12'o4321, 1'b0, 1'b0}, // R6 pass
    {4'd7,  12'o7404, 12'o0101, 1'b0, 12'o1010, 12'o1111, 1'b0, 1'b0}, // R7 or
    {4'd7,  12'o7604, 12'o7777, 1'b0, 12'o0252, 12'o0252, 1'b0, 1'b0}, // R7 load
    {4'd8,  12'o7402, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1}, // R8 halt
    {4'd8,  12'o7412, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b1}, // R8 with sense
    {4'd8,  12'o7642, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b1}  // R8 with clear
  };

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
    end
  endtask

  // Drive one word at the falling edge, sample after the next rising edge
  task automatic issue(input logic v, input logic [11:0] ins, input logic [11:0] a,
                       input logic l, input logic [11:0] s);
    @(negedge clk);
    valid_i = v; instr_i = ins; acc_i = a; link_i = l; sw_i = s;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; instr_i = '0; link_i = 1'b0; acc_i = '0; sw_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "acc",  acc_o, 12'o0);
    chk("R10", "skip", {11'd0, skip_o}, 12'd0);
    chk("R10", "halt", {11'd0, halt_o}, 12'd0);
    chk("R10", "done", {11'd0, done_o}, 12'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][54:51]);
      issue(1'b1, VEC[i][50:39], VEC[i][38:27], VEC[i][26], VEC[i][25:14]);
      chk(tag, "acc",  acc_o, VEC[i][13:2]);
      chk(tag, "skip", {11'd0, skip_o}, {11'd0, VEC[i][1]});
      chk(tag, "halt", {11'd0, halt_o}, {11'd0, VEC[i][0]});
      chk("R1", "done", {11'd0, done_o}, 12'd1);
    end

    // R9: pulses drop on the following idle cycle, accumulator held
    issue(1'b1, 12'o7412, 12'o0700, 1'b0, 12'o0);
    chk("R9", "skip set", {11'd0, skip_o}, 12'd1);
    @(negedge clk);
    chk("R9", "skip drop", {11'd0, skip_o}, 12'd0);
    chk("R9", "halt drop", {11'd0, halt_o}, 12'd0);
    chk("R1", "done drop", {11'd0, done_o}, 12'd0);
    chk("R1", "acc idle hold", acc_o, 12'o0700);

    // R1: foreign words (position 11 set, group one word) ignored
    issue(1'b1, 12'o7601, 12'o1111, 1'b0, 12'o7777);
    chk("R1", "foreign done", {11'd0, done_o}, 12'd0);
    chk("R1", "foreign acc",  acc_o, 12'o0700);
    issue(1'b1, 12'o7210, 12'o0000, 1'b0, 12'o7777);
    chk("R1", "grp1 skip", {11'd0, skip_o}, 12'd0);
    chk("R1", "grp1 acc",  acc_o, 12'o0700);
    // R1: member word with valid low ignored
    issue(1'b0, 12'o7612, 12'o0000, 1'b0, 12'o0000);
    chk("R1", "novalid skip", {11'd0, skip_o}, 12'd0);
    chk("R1", "novalid halt", {11'd0, halt_o}, 12'd0);
    chk("R1", "novalid acc",  acc_o, 12'o0700);

    // R10: reset mid-run clears outputs
    @(negedge clk); valid_i = 1'b1; instr_i = 12'o7412;
    @(negedge clk); valid_i = 1'b0; rst_n = 1'b0;
    #1;
    chk("R10", "reset acc",  acc_o, 12'o0);
    chk("R10", "reset skip", {11'd0, skip_o}, 12'd0);
    rst_n = 1'b1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule